// File: doc/BRIEF.md
# Write Data-Request Burst Sequencer

This block sits on the controller side of a memory write path. When the user logic posts a write request, the block decides whether to take it. If it takes it, the request is held in a short queue. Later the block drives the strobes that tell the user when to supply write data. An early strobe is raised once for each beat of the burst, and a regular strobe follows it by one cycle. For each beat the block also gives the bank, row and column. Bank and row are taken from the request address as they are. The column begins at the address column and steps by one on each beat.

The strobe timing is set by two configuration values: an additive latency and a write latency. They are captured while reset is high. Their sum fixes how many cycles pass between acceptance and the first early strobe. The user holds a request and retries it while `busy` is high. `busy` is raised for refresh, for a row being opened, for the minimum spacing between two accepted requests, and when the queue is full. Write data offered by the user is captured three cycles after each early strobe and shown on a port for checking.

Top module: `wr_burst_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `size_err`, `dreq_early`, `dreq` and `wdata_valid` are all 0.
- R2: A request is accepted in a cycle where `req` is 1, `busy` is 0 and `req_size` is in 4..252. The latency L is `cfg_add_lat + cfg_wr_lat`, sampled during reset, raised to 3 if smaller and capped at 31. When the queue is empty and no burst is running, the first early strobe is high L cycles after the accepting cycle.
- R3: For each accepted request, `dreq_early` is high for exactly `req_size` consecutive cycles.
- R4: `dreq` equals `dreq_early` from the previous cycle.
- R5: The address is split as bank = `req_addr[33:31]`, row = `req_addr[30:14]` and column = `req_addr[13:0]`. On every strobe cycle, bank and row equal the request's fields. The column is the request column plus the beat index, modulo 2^14.
- R6: In the four cycles after an accepting cycle, `busy` is 1, so two acceptances are at least five cycles apart.
- R7: If `refresh` or `row_open` is 1 in a cycle, `busy` is 1 in the next cycle. A request made while `busy` is 1 starts no burst and raises no `size_err`.
- R8: A request made while `busy` is 0 with `req_size` outside 4..252 is rejected. `size_err` is 1 in the next cycle only, and no burst starts.
- R9: Up to four accepted requests wait in order. While four are waiting, `busy` is 1. A queued burst starts at the later of (its accepting cycle + L) and (the last strobe cycle of the previous burst + L).
- R10: For each early-strobe cycle c, the `wdata_in` value of cycle c+3 is shown on `wdata_out` with `wdata_valid` = 1 in cycle c+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; latency config captured while high |
| cfg_add_lat | input | 5 | Additive latency setting |
| cfg_wr_lat | input | 5 | Write latency setting |
| refresh | input | 1 | Refresh in progress, forces busy |
| row_open | input | 1 | Target row being opened, forces busy |
| req | input | 1 | Write request |
| req_addr | input | 34 | Request address (bank, row, column) |
| req_size | input | 8 | Burst size in beats |
| wdata_in | input | 32 | Write data from user logic |
| busy | output | 1 | New request cannot be accepted |
| size_err | output | 1 | Pulse: previous request had an illegal size |
| dreq_early | output | 1 | Early data-request strobe, one cycle per beat |
| dreq | output | 1 | Data-request strobe, early strobe delayed one cycle |
| beat_bank | output | 3 | Bank of the current beat |
| beat_row | output | 17 | Row of the current beat |
| beat_col | output | 14 | Column of the current beat |
| wdata_out | output | 32 | Captured write data |
| wdata_valid | output | 1 | wdata_out holds a newly captured word |

## Verification
The bench goes after several cases. The latency is swept from its clamped minimum through a saturated sum. A wrong clamp or an off-by-one in the wait counter moves every burst by a cycle. Requests are held high for many cycles so that the spacing limit and the full queue both come into play. A design that miscounts queue occupancy or ignores the spacing accepts extra requests, or starts bursts that overlap. Other tests cover column wrap at the top of the field, sizes just inside and just outside the legal range, and refresh and row-open pulses under a held request. These show a sequencer that runs one beat too long or short, fails to wrap, or lets a busy-time or illegal request through.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
  localparam int ADDR_W = 34;
  localparam int BANK_W = 3;
  localparam int ROW_W  = 17;
  localparam int COL_W  = 14;
  localparam int SIZE_W = 8;
  localparam int LAT_W  = 5;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic [SIZE_W-1:0] size;
  } wbs_req_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_WAIT  = 2'd1,
    S_BURST = 2'd2
  } wbs_state_t;
endpackage

// File: rtl/wbs_admit.sv
module wbs_admit
  import wbs_pkg::*;
#(
  parameter int SIZE_MIN = 4,
  parameter int SIZE_MAX = 252,
  parameter int REQ_GAP  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              refresh,
  input  logic              row_open,
  input  logic              q_full,
  output logic              busy,
  output logic              accept,
  output logic              size_err
);
  localparam int GAP_W = (REQ_GAP > 2) ? $clog2(REQ_GAP) : 1;

  logic             ref_q;
  logic             open_q;
  logic [GAP_W-1:0] gap_cnt;
  logic             size_ok;

  assign size_ok = (req_size >= SIZE_W'(SIZE_MIN)) && (req_size <= SIZE_W'(SIZE_MAX));
  assign busy    = ref_q | open_q | (gap_cnt != '0) | q_full;
  assign accept  = req & ~busy & size_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q    <= 1'b0;
      open_q   <= 1'b0;
      gap_cnt  <= '0;
      size_err <= 1'b0;
    end else begin
      ref_q    <= refresh;
      open_q   <= row_open;
      size_err <= req & ~busy & ~size_ok;
      if (accept)
        gap_cnt <= GAP_W'(REQ_GAP - 1);
      else if (gap_cnt != '0)
        gap_cnt <= gap_cnt - 1'b1;
    end
  end

  p_spacing_r6: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);

  p_busy_src_r7: assert property (@(posedge clk) disable iff (rst)
    (refresh || row_open) |=> busy);

  p_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
    size_err |-> ($past(req) && !$past(busy) &&
                  (($past(req_size) < SIZE_W'(SIZE_MIN)) || ($past(req_size) > SIZE_W'(SIZE_MAX)))));
endmodule

// File: rtl/wbs_fifo.sv
module wbs_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 42
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [CW-1:0] count;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_push_room_r9: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);

  p_pop_data_r9: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/wbs_sched.sv
module wbs_sched
  import wbs_pkg::*;
#(
  parameter int LAT_MIN = 3,
  parameter int LAT_MAX = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LAT_W-1:0]  cfg_add_lat,
  input  logic [LAT_W-1:0]  cfg_wr_lat,
  input  logic              q_empty,
  input  wbs_req_t          q_head,
  output logic              q_pop,
  output logic              early,
  output logic [BANK_W-1:0] beat_bank,
  output logic [ROW_W-1:0]  beat_row,
  output logic [COL_W-1:0]  beat_col
);
  // pop edge, wait-state edge and strobe register: three cycles of fixed pipeline
  localparam int PIPE  = 3;
  localparam int SUM_W = LAT_W + 1;

  wbs_state_t        state;
  wbs_req_t          cur;
  logic [LAT_W-1:0]  lat_q;
  logic [LAT_W-1:0]  wait_cnt;
  logic [SIZE_W-1:0] rem;
  logic [SUM_W-1:0]  lat_sum;
  logic [LAT_W-1:0]  lat_clamped;

  assign lat_sum = {1'b0, cfg_add_lat} + {1'b0, cfg_wr_lat};

  always_comb begin
    if (lat_sum < SUM_W'(LAT_MIN))      lat_clamped = LAT_W'(LAT_MIN);
    else if (lat_sum > SUM_W'(LAT_MAX)) lat_clamped = LAT_W'(LAT_MAX);
    else                                lat_clamped = lat_sum[LAT_W-1:0];
  end

  assign q_pop = (state == S_IDLE) && !q_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q     <= lat_clamped;
      state     <= S_IDLE;
      cur       <= '0;
      wait_cnt  <= '0;
      rem       <= '0;
      early     <= 1'b0;
      beat_bank <= '0;
      beat_row  <= '0;
      beat_col  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (!q_empty) begin
            cur      <= q_head;
            wait_cnt <= lat_q - LAT_W'(PIPE);
            state    <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (wait_cnt == '0) begin
            early     <= 1'b1;
            beat_bank <= cur.bank;
            beat_row  <= cur.row;
            beat_col  <= cur.col;
            rem       <= cur.size - 1'b1;
            state     <= S_BURST;
          end else begin
            wait_cnt <= wait_cnt - 1'b1;
          end
        end
        S_BURST: begin
          if (rem == '0) begin
            early <= 1'b0;
            state <= S_IDLE;
          end else begin
            rem      <= rem - 1'b1;
            beat_col <= beat_col + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // independent beat counter for the strobe-length check
  logic [SIZE_W:0] run_len;
  always_ff @(posedge clk) begin
    if (rst)        run_len <= '0;
    else if (early) run_len <= run_len + 1'b1;
    else            run_len <= '0;
  end

  p_burst_len_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(early) |-> (run_len == {1'b0, cur.size}));

  p_col_step_r5: assert property (@(posedge clk) disable iff (rst)
    (early && $past(early)) |-> (beat_col == $past(beat_col) + 1'b1));

  p_bank_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (early && $past(early)) |-> ($stable(beat_bank) && $stable(beat_row)));

  p_no_pop_busy_r9: assert property (@(posedge clk) disable iff (rst)
    early |-> !q_pop);
endmodule

// File: rtl/wbs_capture.sv
module wbs_capture #(
  parameter int DATA_W  = 32,
  parameter int CAP_DLY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              early,
  input  logic [DATA_W-1:0] wdata_in,
  output logic              dreq,
  output logic [DATA_W-1:0] wdata_out,
  output logic              wdata_valid
);
  logic [CAP_DLY:1] dly;

  assign dreq = dly[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      dly         <= '0;
      wdata_valid <= 1'b0;
      wdata_out   <= '0;
    end else begin
      dly         <= {dly[CAP_DLY-1:1], early};
      wdata_valid <= dly[CAP_DLY];
      if (dly[CAP_DLY]) wdata_out <= wdata_in;
    end
  end

  p_capture_r10: assert property (@(posedge clk) disable iff (rst)
    wdata_valid |-> $past(dreq, 3));
endmodule

// File: rtl/wr_burst_seq.sv
module wr_burst_seq
  import wbs_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int QDEPTH   = 4,
  parameter int SIZE_MIN = 4,
  parameter int SIZE_MAX = 252,
  parameter int REQ_GAP  = 5,
  parameter int LAT_MIN  = 3,
  parameter int LAT_MAX  = 31
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LAT_W-1:0]      cfg_add_lat,
  input  logic [LAT_W-1:0]      cfg_wr_lat,
  input  logic                  refresh,
  input  logic                  row_open,
  input  logic                  req,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [SIZE_W-1:0]     req_size,
  input  logic [DATA_W-1:0]     wdata_in,
  output logic                  busy,
  output logic                  size_err,
  output logic                  dreq_early,
  output logic                  dreq,
  output logic [BANK_W-1:0]     beat_bank,
  output logic [ROW_W-1:0]      beat_row,
  output logic [COL_W-1:0]      beat_col,
  output logic [DATA_W-1:0]     wdata_out,
  output logic                  wdata_valid
);
  localparam int ENT_W = $bits(wbs_req_t);

  logic     accept;
  logic     q_full;
  logic     q_empty;
  logic     q_pop;
  wbs_req_t new_ent;
  wbs_req_t head_ent;

  assign new_ent.bank = req_addr[ADDR_W-1 -: BANK_W];
  assign new_ent.row  = req_addr[COL_W +: ROW_W];
  assign new_ent.col  = req_addr[COL_W-1:0];
  assign new_ent.size = req_size;

  wbs_admit #(
    .SIZE_MIN (SIZE_MIN),
    .SIZE_MAX (SIZE_MAX),
    .REQ_GAP  (REQ_GAP)
  ) u_admit (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .req_size (req_size),
    .refresh  (refresh),
    .row_open (row_open),
    .q_full   (q_full),
    .busy     (busy),
    .accept   (accept),
    .size_err (size_err)
  );

  wbs_fifo #(
    .DEPTH (QDEPTH),
    .W     (ENT_W)
  ) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (accept),
    .din   (new_ent),
    .pop   (q_pop),
    .dout  (head_ent),
    .empty (q_empty),
    .full  (q_full)
  );

  wbs_sched #(
    .LAT_MIN (LAT_MIN),
    .LAT_MAX (LAT_MAX)
  ) u_sched (
    .clk         (clk),
    .rst         (rst),
    .cfg_add_lat (cfg_add_lat),
    .cfg_wr_lat  (cfg_wr_lat),
    .q_empty     (q_empty),
    .q_head      (head_ent),
    .q_pop       (q_pop),
    .early       (dreq_early),
    .beat_bank   (beat_bank),
    .beat_row    (beat_row),
    .beat_col    (beat_col)
  );

  wbs_capture #(
    .DATA_W  (DATA_W),
    .CAP_DLY (3)
  ) u_capture (
    .clk         (clk),
    .rst         (rst),
    .early       (dreq_early),
    .wdata_in    (wdata_in),
    .dreq        (dreq),
    .wdata_out   (wdata_out),
    .wdata_valid (wdata_valid)
  );

  p_follow_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(dreq_early) |-> dreq);

  p_quiet_start_r1: assert property (@(posedge clk)
    rst |=> (!dreq_early && !size_err && !wdata_valid));

  p_ignore_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (req && busy) |=> !size_err);
endmodule

// File: tb/wr_burst_seq_bench.sv
module wr_burst_seq_bench;
  localparam int QD   = 4;
  localparam int MAXB = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  cfg_add_lat = '0;
  logic [4:0]  cfg_wr_lat = '0;
  logic        refresh = 1'b0;
  logic        row_open = 1'b0;
  logic        req = 1'b0;
  logic [33:0] req_addr = '0;
  logic [7:0]  req_size = '0;
  logic [31:0] wdata_in = '0;
  logic        busy, size_err, dreq_early, dreq, wdata_valid;
  logic [2:0]  beat_bank;
  logic [16:0] beat_row;
  logic [13:0] beat_col;
  logic [31:0] wdata_out;

  wr_burst_seq u_wr_burst_seq (
    .clk(clk), .rst(rst), .cfg_add_lat(cfg_add_lat), .cfg_wr_lat(cfg_wr_lat),
    .refresh(refresh), .row_open(row_open), .req(req), .req_addr(req_addr),
    .req_size(req_size), .wdata_in(wdata_in), .busy(busy), .size_err(size_err),
    .dreq_early(dreq_early), .dreq(dreq), .beat_bank(beat_bank), .beat_row(beat_row),
    .beat_col(beat_col), .wdata_out(wdata_out), .wdata_valid(wdata_valid)
  );

  always #10 clk = ~clk;  // 50 MHz

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // bench model state
  int lat;
  int cyc;
  int nacc;
  int a_t[MAXB], a_start[MAXB], a_end[MAXB], a_col[MAXB], a_bank[MAXB], a_row[MAXB];
  int last_acc, last_end, last_bad;
  bit busy_src_prev;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
    end
  endtask

  function automatic int burst_at(int k);
    for (int i = 0; i < nacc; i++)
      if (k >= a_start[i] && k <= a_end[i]) return i;
    return -1;
  endfunction

  function automatic int occupancy(int c);
    int n = 0;
    for (int i = 0; i < nacc; i++) begin
      if (a_t[i] < c) n++;
      if (a_start[i] - lat + 2 <= c) n--;
    end
    return n;
  endfunction

  function automatic bit busy_exp(int c);
    bit g = (last_acc > -1000) && (c - last_acc >= 1) && (c - last_acc <= 4);
    return g || busy_src_prev || (occupancy(c) >= QD);
  endfunction

  function automatic logic [31:0] pat(int k);
    return 32'hC0DE_0000 ^ 32'(k * 7919);
  endfunction

  // stimulus for the coming cycle
  bit          s_req, s_ref, s_open;
  logic [33:0] s_addr;
  logic [7:0]  s_size;

  task automatic step();
    int b;
    bit bx;
    @(negedge clk);
    cyc++;
    b = burst_at(cyc);
    bx = busy_exp(cyc);
    chk(busy == bx, "R6/R7/R9", "busy", busy, bx);
    chk(dreq_early == (b >= 0), "R2/R3/R9", "dreq_early", dreq_early, b >= 0);
    chk(dreq == (burst_at(cyc - 1) >= 0), "R4", "dreq", dreq, burst_at(cyc - 1) >= 0);
    chk(size_err == (last_bad == cyc - 1), "R8", "size_err", size_err, last_bad == cyc - 1);
    chk(wdata_valid == (burst_at(cyc - 4) >= 0), "R10", "wdata_valid", wdata_valid,
        burst_at(cyc - 4) >= 0);
    if (wdata_valid && burst_at(cyc - 4) >= 0)
      chk(wdata_out == pat(cyc - 1), "R10", "wdata_out", wdata_out, pat(cyc - 1));
    if (b >= 0) begin
      chk(beat_bank == 3'(a_bank[b]), "R5", "beat_bank", beat_bank, a_bank[b]);
      chk(beat_row == 17'(a_row[b]), "R5", "beat_row", beat_row, a_row[b]);
      chk(beat_col == 14'((a_col[b] + cyc - a_start[b]) % 16384), "R5", "beat_col", beat_col,
          (a_col[b] + cyc - a_start[b]) % 16384);
    end
    // drive and update model
    req = s_req; req_addr = s_addr; req_size = s_size;
    refresh = s_ref; row_open = s_open; wdata_in = pat(cyc);
    if (s_req && !bx) begin
      if (s_size >= 4 && s_size <= 252) begin
        a_t[nacc]     = cyc;
        a_start[nacc] = (cyc + lat > last_end + lat) ? cyc + lat : last_end + lat;
        a_end[nacc]   = a_start[nacc] + int'(s_size) - 1;
        a_bank[nacc]  = int'(s_addr[33:31]);
        a_row[nacc]   = int'(s_addr[30:14]);
        a_col[nacc]   = int'(s_addr[13:0]);
        last_end = a_end[nacc];
        last_acc = cyc;
        if (nacc < MAXB - 1) nacc++;
      end else begin
        last_bad = cyc;
      end
    end
    busy_src_prev = s_ref || s_open;
  endtask

  task automatic drive(bit r, logic [33:0] a, logic [7:0] s, bit rf, bit op);
    s_req = r; s_addr = a; s_size = s; s_ref = rf; s_open = op;
    step();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, '0, '0, 0, 0);
  endtask

  function automatic logic [33:0] mk_addr(int bank, int row, int col);
    return {3'(bank), 17'(row), 14'(col)};
  endfunction

  task automatic do_reset(int al, int wl);
    int sum;
    rst = 1'b1; cfg_add_lat = 5'(al); cfg_wr_lat = 5'(wl);
    req = 0; refresh = 0; row_open = 0;
    repeat (3) @(negedge clk);
    sum = al + wl;
    lat = (sum < 3) ? 3 : (sum > 31) ? 31 : sum;
    nacc = 0; last_acc = -10000; last_end = -10000; last_bad = -10000;
    busy_src_prev = 0; cyc = 0;
    @(negedge clk);
    rst = 1'b0;
    // R1: still in reset output state during first active cycle
    chk(busy == 0, "R1", "busy", busy, 0);
    chk(dreq_early == 0, "R1", "dreq_early", dreq_early, 0);
    chk(dreq == 0, "R1", "dreq", dreq, 0);
    chk(size_err == 0, "R1", "size_err", size_err, 0);
    chk(wdata_valid == 0, "R1", "wdata_valid", wdata_valid, 0);
  endtask

  initial begin
    int cfgs[5][2];
    int sizes[6];
    cfgs = '{'{2, 1}, '{1, 1}, '{3, 5}, '{20, 20}, '{0, 11}};
    sizes = '{4, 5, 6, 9, 16, 33};
    for (int c = 0; c < 5; c++) begin
      do_reset(cfgs[c][0], cfgs[c][1]);
      // R2 R3 R5: isolated requests across sizes and addresses
      for (int s = 0; s < 6; s++) begin
        drive(1, mk_addr(s + c, 1000 * s + 3 * c + 1, 100 * s + c), 8'(sizes[s]), 0, 0);
        idle(sizes[s] + lat + 8);
      end
      // R6 R9: request held for many cycles, fills queue
      for (int i = 0; i < 45; i++) drive(1, mk_addr(i % 8, 500 + i, 40 * i), 8'd20, 0, 0);
      idle(200);
      // R7: refresh and row-open under a held request
      drive(0, '0, '0, 1, 0);
      for (int i = 0; i < 3; i++) drive(1, mk_addr(1, 7, 9), 8'd4, 1, 0);
      for (int i = 0; i < 2; i++) drive(1, mk_addr(2, 8, 10), 8'd5, 0, 1);
      for (int i = 0; i < 3; i++) drive(1, mk_addr(3, 9, 11), 8'd6, 0, 0);
      idle(60);
      // R8: illegal sizes around both limits, then legal edges
      drive(1, mk_addr(0, 1, 2), 8'd0, 0, 0);   idle(3);
      drive(1, mk_addr(0, 1, 2), 8'd3, 0, 0);   idle(3);
      drive(1, mk_addr(0, 1, 2), 8'd253, 0, 0); idle(3);
      drive(1, mk_addr(0, 1, 2), 8'd255, 0, 0); idle(3);
      // R8 held illegal request
      for (int i = 0; i < 4; i++) drive(1, mk_addr(0, 1, 2), 8'd2, 0, 0);
      idle(3);
      // R5: column wrap at top of field
      drive(1, mk_addr(7, 131071, 16382), 8'd6, 0, 0);
      idle(50);
    end
    // R3: largest legal burst
    do_reset(4, 6);
    drive(1, mk_addr(5, 77, 16000), 8'd252, 0, 0);
    drive(1, mk_addr(6, 78, 16383), 8'd4, 0, 0); // ignored, R6 spacing
    idle(280);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule